// File: doc/BRIEF.md
# Barrel Shift/Rotate Register with Byte Parity

This block holds a data word of configurable width. A load strobe fills it from a parallel input. An execute strobe replaces the word with a moved copy of itself. The move is a logical shift or a rotation, to the left or to the right. The number of positions to move comes from an input port, and every move finishes in a single clock cycle through a barrel network.

A small parity unit sits beside the register. It keeps an even-parity bit for the least significant byte of the register. On its own, it also checks an incoming byte together with its parity bit and flags a mismatch. A host loads a word, issues one or more execute strobes with an opcode and a count, and reads the result and its parity from the outputs.

Top module: `usr_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes all zeros, so `dout` is 0 and `par_out` is 0 after that edge.
- R2: With `rst` low and `load` high at a rising edge, `dout` takes the value of `din`, whether `exec` is high or low.
- R3: With `rst` and `load` low, `exec` high and `op` = 2'b00, the register shifts left by `amt` positions and fills the vacated low bits with zeros.
- R4: With `op` = 2'b01, the register shifts right by `amt` positions and fills the vacated high bits with zeros.
- R5: With `op` = 2'b10, the register rotates left by `amt` modulo WIDTH positions.
- R6: With `op` = 2'b11, the register rotates right by `amt` modulo WIDTH positions.
- R7: A shift (`op` = 2'b00 or 2'b01) whose `amt` is WIDTH or more leaves the register at zero.
- R8: With `rst`, `load` and `exec` all low at an edge, the register keeps its value.
- R9: `par_out` is the XOR of bits 7 to 0 of the register, which is even parity over the low byte.
- R10: `par_err` is 1 exactly when the XOR of the eight bits of `chk_byte` and `chk_par` is 1. It depends only on those inputs and not on the clock.
- R11: A high `rst` overrides `load` and `exec` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load strobe |
| din | input | WIDTH | Word to load |
| op | input | 2 | Move kind: 00 shl, 01 shr, 10 rol, 11 ror |
| amt | input | AMT_W | Number of positions to move |
| exec | input | 1 | Execute strobe for the move |
| dout | output | WIDTH | Current register contents |
| par_out | output | 1 | Even parity of register bits 7..0 |
| chk_byte | input | 8 | Received byte to check |
| chk_par | input | 1 | Parity bit received with `chk_byte` |
| par_err | output | 1 | High when the byte and its parity bit disagree |

## Verification
The assertions assume that `amt` is wide enough to hold values of WIDTH and above, so the clearing rule for shifts can be reached. They also assume that strobes change only between clock edges. The bench uses a 16-bit register with a 6-bit count and sweeps every count from 0 to 63 for all four opcodes over several contrasting words. It drives inputs only on falling edges. This covers the counts below the width, equal to it and above it. The bench also checks every byte with both parity bits.

// File: rtl/usr_pkg.sv
package usr_pkg;

    localparam int PAR_W = 8;

    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SHR = 2'b01,
        OP_ROL = 2'b10,
        OP_ROR = 2'b11
    } op_e;

    // Control decoded from an opcode
    typedef struct packed {
        logic rot;
        logic left;
    } mv_ctl_t;

    function automatic mv_ctl_t decode_op(input logic [1:0] code);
        mv_ctl_t c;
        c.rot  = code[1];
        c.left = (code == OP_SHL) || (code == OP_ROL);
        return c;
    endfunction

    function automatic logic even_par(input logic [PAR_W-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/usr_amt_ctrl.sv
module usr_amt_ctrl
    import usr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AMT_W = 6,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [1:0]       op,
    input  logic [AMT_W-1:0] amt,
    output mv_ctl_t          ctl,
    output logic [LOG_W-1:0] stage_cnt,
    output logic             clr
);

    logic [AMT_W-1:0] amt_mod;

    always_comb begin
        ctl       = decode_op(op);
        // Counts at or past the width wrap for rotates
        amt_mod   = amt % AMT_W'(WIDTH);
        stage_cnt = LOG_W'(amt_mod);
        // Shifts with count at or past the width clear the word
        clr       = !ctl.rot && (int'(amt) >= WIDTH);
    end

endmodule

// File: rtl/usr_barrel.sv
module usr_barrel
    import usr_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] d_in,
    input  mv_ctl_t          ctl,
    input  logic [LOG_W-1:0] stage_cnt,
    input  logic             clr,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg [LOG_W+1];

    assign stg[0] = d_in;

    // One stage per count bit; stage s moves by 2**s
    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int N = 1 << s;
        logic [WIDTH-1:0] moved;
        logic [WIDTH-1:0] wrap;

        always_comb begin
            if (ctl.left) begin
                moved = stg[s] << N;
                wrap  = stg[s] >> (WIDTH - N);
            end else begin
                moved = stg[s] >> N;
                wrap  = stg[s] << (WIDTH - N);
            end
            if (!ctl.rot) begin
                wrap = '0;
            end
        end

        assign stg[s+1] = stage_cnt[s] ? (moved | wrap) : stg[s];
    end

    assign d_out = clr ? '0 : stg[LOG_W];

endmodule

// File: rtl/usr_parity.sv
module usr_parity
    import usr_pkg::*;
(
    input  logic [PAR_W-1:0] gen_byte,
    input  logic [PAR_W-1:0] rx_byte,
    input  logic             rx_par,
    output logic             gen_par,
    output logic             err
);

    assign gen_par = even_par(gen_byte);
    assign err     = even_par(rx_byte) ^ rx_par;

endmodule

// File: rtl/usr_top.sv
module usr_top
    import usr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AMT_W = 6,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       op,
    input  logic [AMT_W-1:0] amt,
    input  logic             exec,
    output logic [WIDTH-1:0] dout,
    output logic             par_out,
    input  logic [PAR_W-1:0] chk_byte,
    input  logic             chk_par,
    output logic             par_err
);

    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_moved;
    mv_ctl_t          ctl;
    logic [LOG_W-1:0] stage_cnt;
    logic             clr;

    usr_amt_ctrl #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_amt (
        .op        (op),
        .amt       (amt),
        .ctl       (ctl),
        .stage_cnt (stage_cnt),
        .clr       (clr)
    );

    usr_barrel #(.WIDTH(WIDTH)) u_bar (
        .d_in      (q),
        .ctl       (ctl),
        .stage_cnt (stage_cnt),
        .clr       (clr),
        .d_out     (q_moved)
    );

    usr_parity u_par (
        .gen_byte (q[PAR_W-1:0]),
        .rx_byte  (chk_byte),
        .rx_par   (chk_par),
        .gen_par  (par_out),
        .err      (par_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (exec) begin
            q <= q_moved;
        end
    end

    assign dout = q;

endmodule

// File: rtl/usr_chk.sv
module usr_chk #(
    parameter int WIDTH = 16,
    parameter int AMT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic [WIDTH-1:0] din,
    input logic [1:0]       op,
    input logic [AMT_W-1:0] amt,
    input logic             exec,
    input logic [WIDTH-1:0] dout,
    input logic             par_out
);

    // R1 R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == '0 && !par_out));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> dout == $past(din));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !exec) |=> $stable(dout));

    // R5 R6
    rot_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && exec && op[1]) |=> $countones(dout) == $countones($past(dout)));

    // R7
    shift_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && exec && !op[1] && int'(amt) >= WIDTH) |=> dout == '0);

    // R3 R4
    shift_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && exec && !op[1]) |=> $countones(dout) <= $countones($past(dout)));

endmodule

bind usr_top usr_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .din     (din),
    .op      (op),
    .amt     (amt),
    .exec    (exec),
    .dout    (dout),
    .par_out (par_out)
);

// File: tb/sim_usr_top.sv
module sim_usr_top;

    localparam int W  = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          load;
    logic [W-1:0]  din;
    logic [1:0]    op;
    logic [AW-1:0] amt;
    logic          exec;
    logic [W-1:0]  dout;
    logic          par_out;
    logic [7:0]    chk_byte;
    logic          chk_par;
    logic          par_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    usr_top #(.WIDTH(W), .AMT_W(AW)) u0 (
        .clk(clk), .rst(rst), .load(load), .din(din), .op(op), .amt(amt),
        .exec(exec), .dout(dout), .par_out(par_out), .chk_byte(chk_byte),
        .chk_par(chk_par), .par_err(par_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model(input int d, input int code, input int a);
        int mask = (1 << W) - 1;
        int r = a % W;
        case (code)
            0: return (a >= W) ? 0 : ((d << a) & mask);
            1: return (a >= W) ? 0 : ((d >> a) & mask);
            2: return ((d << r) | (d >> (W - r))) & mask;
            default: return ((d >> r) | (d << (W - r))) & mask;
        endcase
    endfunction

    function automatic int par8(input int d);
        int p = 0;
        for (int i = 0; i < 8; i++) p ^= (d >> i) & 1;
        return p;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pats[6] = '{16'h0001, 16'h8000, 16'hA5C3, 16'hFFFF, 16'h1234, 16'h7E81};
        rst = 1'b1; load = 1'b1; exec = 1'b1; din = 16'hBEEF;
        op = 2'b10; amt = 6'd3; chk_byte = 8'h00; chk_par = 1'b0;
        @(negedge clk);
        step();
        // R1 R11: reset wins over load and exec
        check("R1 reset dout", int'(dout), 0);
        check("R11 reset parity", int'(par_out), 0);
        rst = 1'b0; load = 1'b0; exec = 1'b0;

        // R2: load wins over exec in the same cycle
        din = 16'h00F1; load = 1'b1; exec = 1'b1; op = 2'b00; amt = 6'd4;
        step();
        check("R2 load priority", int'(dout), 16'h00F1);
        load = 1'b0; exec = 1'b0;
        // R8: idle cycles keep the word
        din = 16'h5555;
        step(); step();
        check("R8 hold", int'(dout), 16'h00F1);

        foreach (pats[p]) begin
            for (int code = 0; code < 4; code++) begin
                for (int a = 0; a < 64; a++) begin
                    din = W'(pats[p]); load = 1'b1;
                    step();
                    load = 1'b0;
                    check("R2 load", int'(dout), pats[p]);
                    op = 2'(code); amt = AW'(a); exec = 1'b1;
                    step();
                    exec = 1'b0;
                    case (code)
                        0: check(a >= W ? "R7 shl clear" : "R3 shl", int'(dout), model(pats[p], code, a));
                        1: check(a >= W ? "R7 shr clear" : "R4 shr", int'(dout), model(pats[p], code, a));
                        2: check("R5 rol", int'(dout), model(pats[p], code, a));
                        default: check("R6 ror", int'(dout), model(pats[p], code, a));
                    endcase
                    check("R9 parity", int'(par_out), par8(model(pats[p], code, a)));
                end
            end
        end

        // R3 chained: two moves in a row
        din = 16'h0003; load = 1'b1; step(); load = 1'b0;
        op = 2'b00; amt = 6'd5; exec = 1'b1; step();
        op = 2'b11; amt = 6'd7; step(); exec = 1'b0;
        check("R3 R6 chained", int'(dout), model(model(3, 0, 5), 3, 7));

        // R10: every byte with both parity bits
        for (int b = 0; b < 256; b++) begin
            for (int pb = 0; pb < 2; pb++) begin
                chk_byte = 8'(b); chk_par = 1'(pb);
                #1;
                check("R10 checker", int'(par_err), par8(b) ^ pb);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule